// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Chain

This block is a wide synchronous up-counter assembled from identical 8-bit counter slices. Each slice holds one byte of the count. It has a synchronous parallel preset, an active-low advance input and an active-low "all ones" flag. Four slices form a 32-bit counter. The lowest slice carries the least significant byte.

A slice above the lowest advances only when the active-low flags of every slice below it are low. Its advance input is therefore the OR of those flags, together with the external active-low enable. On the edge where the lower bytes roll over from all ones, the upper slice steps by one and the lower slices wrap to zero. Their flags then return high, and the upper slices go back to holding. A shared active-low load strobe presets all slices at once. Data enters and leaves as plain parallel words, so the block has no stream handshake.

Top module: `counter_chain`

## Requirements
- R1: When `load_n` is low at a rising clock edge, `count` takes the value of `preset` after that edge.
- R2: Loading takes priority over counting and happens whatever the level of `count_en_n`.
- R3: When `load_n` is high and `count_en_n` is low at a rising edge, `count` becomes its previous value plus one.
- R4: When `load_n` and `count_en_n` are both high at a rising edge, `count` keeps its value.
- R5: Counting from 0xFFFFFFFF with `count_en_n` low and `load_n` high wraps `count` to 0x00000000 on the next edge.
- R6: During counting, byte k of `count` (bits 8k+7 down to 8k, k ≥ 1) changes only on an edge where every lower byte is 0xFF. On that edge it steps up by one and the lower bytes become 0x00.
- R7: `chain_tc_n` is low exactly while `count` is 0xFFFFFFFF and `count_en_n` is low, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Shared synchronous preset strobe, active low |
| preset | input | 32 | Value loaded into the chain |
| count_en_n | input | 1 | External count enable for the lowest slice, active low |
| count | output | 32 | Current count; byte 0 comes from the lowest slice |
| chain_tc_n | output | 1 | Terminal count of the whole chain, active low |

## Verification
A slice that advances on the wrong flag shows up at `count` on the very next edge. An upper byte then steps while a lower byte is not 0xFF, or it fails to step at a byte rollover. A byte that latches the wrong preset, or that drops a load held against a high enable, is visible one edge after the strobe. A broken flag combine shows at `chain_tc_n` combinationally, in the same cycle the count or enable reaches the offending value. The bench therefore checks the flag before each edge and the count after each edge. It also parks the counter just below each byte boundary so that every rollover path is exercised.

// File: rtl/counter_chain_pkg.sv
package counter_chain_pkg;
  // Bit width of one counter slice
  localparam int unsigned DEF_SLICE_W = 8;
  // Number of slices in the default chain
  localparam int unsigned DEF_SLICES  = 4;

  // How the per-slice enables are formed from lower flags
  typedef enum logic {
    OR_RIPPLE = 1'b0,  // running OR passed up the chain
    OR_FLAT   = 1'b1   // separate wide OR for each slice
  } or_style_e;
endpackage

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         en_n,
  output logic [W-1:0] q,
  output logic         tc_n
);
  localparam logic [W-1:0] ONE = W'(1);

  // Load wins over count; enable high holds.
  always_ff @(posedge clk) begin
    if (!load_n)    q <= preset;
    else if (!en_n) q <= q + ONE;
  end

  // Flag low only on the all-ones value of this slice
  assign tc_n = ~(&q);
endmodule

// File: rtl/slice_enable_net.sv
module slice_enable_net
  import counter_chain_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter or_style_e   STYLE = OR_FLAT
) (
  input  logic         ext_en_n,
  input  logic [N-1:0] tc_n,
  output logic [N-1:0] en_n,
  output logic         chain_tc_n
);
  if (STYLE == OR_RIPPLE) begin : g_ripple
    logic [N:0] run;
    assign run[0] = ext_en_n;
    for (genvar i = 0; i < N; i++) begin : g_stage
      assign en_n[i]  = run[i];
      assign run[i+1] = run[i] | tc_n[i];
    end
    assign chain_tc_n = run[N];
  end else begin : g_flat
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_low
        assign en_n[i] = ext_en_n;
      end else begin : g_up
        assign en_n[i] = ext_en_n | (|tc_n[i-1:0]);
      end
    end
    assign chain_tc_n = ext_en_n | (|tc_n);
  end
endmodule

// File: rtl/counter_chain.sv
module counter_chain
  import counter_chain_pkg::*;
#(
  parameter int unsigned SLICE_W = DEF_SLICE_W,
  parameter int unsigned SLICES  = DEF_SLICES,
  parameter or_style_e   STYLE   = OR_FLAT,
  localparam int unsigned TOTAL_W = SLICE_W * SLICES
) (
  input  logic               clk,
  input  logic               load_n,
  input  logic [TOTAL_W-1:0] preset,
  input  logic               count_en_n,
  output logic [TOTAL_W-1:0] count,
  output logic               chain_tc_n
);
  logic [SLICES-1:0] sl_tc_n;
  logic [SLICES-1:0] sl_en_n;

  slice_enable_net #(.N(SLICES), .STYLE(STYLE)) u_en_net (
    .ext_en_n   (count_en_n),
    .tc_n       (sl_tc_n),
    .en_n       (sl_en_n),
    .chain_tc_n (chain_tc_n)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    ctr_slice #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .load_n (load_n),
      .preset (preset[s*SLICE_W +: SLICE_W]),
      .en_n   (sl_en_n[s]),
      .q      (count[s*SLICE_W +: SLICE_W]),
      .tc_n   (sl_tc_n[s])
    );
  end
endmodule

// File: rtl/counter_chain_checker.sv
module counter_chain_checker #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned SLICES  = 4,
  localparam int unsigned TOTAL_W = SLICE_W * SLICES
) (
  input logic               clk,
  input logic               load_n,
  input logic [TOTAL_W-1:0] preset,
  input logic               count_en_n,
  input logic [TOTAL_W-1:0] count,
  input logic               chain_tc_n
);
  // The count is undefined until the first load; stay quiet until then.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!load_n) armed <= 1'b1;

  // R1, R2: preset lands whatever the enable
  p_load_r1: assert property (@(posedge clk) disable iff (!armed)
    !load_n |=> count == $past(preset));

  p_load_prio_r2: assert property (@(posedge clk) disable iff (!armed)
    (!load_n && count_en_n) |=> count == $past(preset));

  p_step_r3: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !count_en_n) |=> count == $past(count) + TOTAL_W'(1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (load_n && count_en_n) |=> $stable(count));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !count_en_n && (&count)) |=> count == '0);

  p_upper_r6: assert property (@(posedge clk) disable iff (!armed)
    (load_n && !count_en_n && !(&count[SLICE_W-1:0]))
      |=> $stable(count[TOTAL_W-1:SLICE_W]));

  p_flag_r7: assert property (@(posedge clk) disable iff (!armed)
    chain_tc_n == !((&count) && !count_en_n));
endmodule

bind counter_chain counter_chain_checker #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chain_chk (
  .clk        (clk),
  .load_n     (load_n),
  .preset     (preset),
  .count_en_n (count_en_n),
  .count      (count),
  .chain_tc_n (chain_tc_n)
);

// File: tb/test_counter_chain.sv
module test_counter_chain;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        load_n = 1'b1;
  logic [31:0] preset = '0;
  logic        count_en_n = 1'b1;
  logic [31:0] count;
  logic        chain_tc_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] exp_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  counter_chain i_counter_chain (
    .clk(clk), .load_n(load_n), .preset(preset),
    .count_en_n(count_en_n), .count(count), .chain_tc_n(chain_tc_n)
  );

  function automatic logic [31:0] next_val(logic [31:0] cur, logic ld_n,
                                           logic [31:0] val, logic en_n);
    if (!ld_n) return val;
    if (!en_n) return cur + 32'd1;
    return cur;
  endfunction

  function automatic logic exp_flag(logic [31:0] cur, logic en_n);
    return !((cur == 32'hFFFF_FFFF) && !en_n);
  endfunction

  function automatic string req_of(logic [31:0] cur, logic ld_n, logic en_n);
    if (!ld_n) return en_n ? "R2" : "R1";
    if (en_n) return "R4";
    if (cur == 32'hFFFF_FFFF) return "R5";
    if (cur[7:0] == 8'hFF) return "R6";
    return "R3";
  endfunction

  // One clock: drive at the falling edge, check the flag, step, check the count.
  task automatic step(input logic ld_n, input logic [31:0] val, input logic en_n,
                      input bit armed);
    string rq;
    load_n = ld_n; preset = val; count_en_n = en_n;
    #1;
    if (armed) begin
      checks++;
      if (chain_tc_n !== exp_flag(exp_q, en_n)) begin
        failures++;
        $display("FAIL R7 chain_tc_n actual=%b expected=%b (count=%h)",
                 chain_tc_n, exp_flag(exp_q, en_n), exp_q);
      end
    end
    rq = req_of(exp_q, ld_n, en_n);
    if (armed || !ld_n) exp_q = next_val(exp_q, ld_n, val, en_n);
    @(posedge clk);
    @(negedge clk);
    if (armed || !ld_n) begin
      checks++;
      if (count !== exp_q) begin
        failures++;
        $display("FAIL %s count actual=%h expected=%h", rq, count, exp_q);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    // First load establishes the state (R1)
    step(1'b0, 32'h1234_5678, 1'b0, 1'b0);
    // Hold gap, then counting (R4, R3)
    step(1'b1, 32'h0, 1'b1, 1'b1);
    step(1'b1, 32'h0, 1'b0, 1'b1);
    // Load against a high enable (R2)
    step(1'b0, 32'hFFFF_FFFE, 1'b1, 1'b1);
    step(1'b1, 32'h0, 1'b0, 1'b1);            // reach all ones
    step(1'b1, 32'h0, 1'b1, 1'b1);            // all ones, enable high: flag high (R7)
    step(1'b1, 32'h0, 1'b0, 1'b1);            // flag low then wrap (R5, R7)
    step(1'b1, 32'h0, 1'b0, 1'b1);
    // Rollover at each byte boundary (R6)
    for (int b = 1; b < 4; b++) begin
      logic [31:0] v;
      v = (32'h1 << (8*b)) - 32'd2;
      v = v | 32'hA500_0000 & ~((32'h1 << (8*b)) - 1) & (b == 3 ? 32'h0 : 32'hFFFF_FFFF);
      step(1'b0, v, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) step(1'b1, 32'h0, (k == 1), 1'b1);
    end
    // Load with enable low overrides counting (R1)
    step(1'b1, 32'h0, 1'b0, 1'b1);
    step(1'b0, 32'h00FF_FFFF, 1'b0, 1'b1);
    step(1'b1, 32'h0, 1'b0, 1'b1);
    // Constrained random run
    for (int i = 0; i < 3000; i++) begin
      logic        ld;
      logic        en;
      logic [31:0] v;
      logic [31:0] r;
      r  = $urandom;
      ld = ($urandom_range(0, 19) != 0);
      en = ($urandom_range(0, 9) < 3);
      case ($urandom_range(0, 3))
        0: v = r;
        1: v = r | 32'h0000_00F0;
        2: v = r | 32'h00FF_FFF8;
        default: v = 32'hFFFF_FFF0 | (r & 32'hF);
      endcase
      step(ld, v, en, 1'b1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule